// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store unit and a local bus that only accepts naturally aligned transfers. It takes one operand request at a time: an address, a size (byte, word or long), a direction and, for stores, the write data. When the reference is aligned, or is a single byte, it goes out as one bus transfer. When it is not aligned, the block breaks it into a short series of aligned transfers and issues one each cycle, in ascending address order. The low address bits decide how many transfers there are, not the operand size alone.

For loads, the block joins the returned pieces into one right-justified, zero-extended 32-bit value. For stores, it places the right bytes of the operand on each transfer, with the most significant byte at the lowest address. The bus is assumed to complete every transfer in the cycle it is issued. A `done` pulse marks the last transfer, and the load result is valid in that same cycle.

The control is a two-state machine. ST_IDLE waits for a request. The transition ACCEPT (valid and ready) captures the request and its transfer plan and moves to ST_XFER. In ST_XFER, the transition STEP advances to the next piece while pieces remain. The transition FINISH returns to ST_IDLE on the last piece.

Top module: `mis_split`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a cycle with `req_valid` and `req_ready` both high. Its first bus transfer appears in the next cycle, at the request address. `req_ready` stays low, and request inputs are ignored, until the cycle after `done`.
- R2: A request of size code 0 (byte), or a word (code 1) with address bit 0 clear, or a long (code 2) with address bits [1:0] equal to 00, is issued as a single transfer of its own size, with `done` in that cycle.
- R3: A word with address bit 0 set is issued as two byte transfers.
- R4: A long with address bit 0 set is issued as a byte transfer, then a word transfer, then a byte transfer.
- R5: A long with address bits [1:0] equal to 10 is issued as two word transfers.
- R6: The first transfer's address is the request address. Each later transfer's address is the previous address plus the previous piece's size in bytes (1, 2 or 4). Every transfer is naturally aligned to its own size.
- R7: `bus_write` follows the request direction. On a store, each transfer carries its bytes right-justified on `bus_wdata`, taken in big-endian order: the first transfer carries the most significant bytes of the operand (its right-justified low 1, 2 or 4 bytes). Unused upper lanes are zero, and on loads `bus_wdata` is zero.
- R8: On a load, `rdata` in the `done` cycle equals the pieces joined in issue order, first piece most significant, zero-extended to 32 bits. Only the low 1, 2 or 4 bytes of `bus_rdata` are used, according to the piece size. Outside a load's `done` cycle, `rdata` is zero.
- R9: `done` is high only on the last transfer of a request. `bus_valid` is low whenever no request is in progress.
- R10: After reset, `req_ready` is high, and `bus_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store operand, right-justified |
| bus_valid | output | 1 | Transfer issued this cycle |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Transfer store bytes, right-justified |
| bus_rdata | input | 32 | Transfer load bytes, right-justified, same cycle |
| done | output | 1 | Last transfer of the request |
| rdata | output | 32 | Assembled load result |

## Verification
A fault in the latched plan shows up as a wrong `bus_size` on the first transfer, or as `done` arriving a cycle early or late. A fault in the address register shows up one cycle after the faulty step, as a wrong `bus_addr`. A fault in the bytes-remaining count shows up at once as misplaced store lanes on `bus_wdata`. A corrupt load accumulator stays hidden until the `done` cycle, where `rdata` no longer matches the bytes in memory. The bench returns junk in the unused upper lanes of `bus_rdata`, so any use of those lanes changes the result.

// File: rtl/mis_split_pkg.sv
package mis_split_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned MAX_PCS  = 3;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_WORD: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/mis_split_plan.sv
module mis_split_plan
    import mis_split_pkg::*;
(
    input  logic [1:0]               lo_addr,
    input  logic [1:0]               op_size,
    output logic [1:0]               n_pieces,
    output logic [MAX_PCS-1:0][1:0]  piece_sz
);

    always_comb begin
        n_pieces    = 2'd1;
        piece_sz[0] = op_size;
        piece_sz[1] = SZ_BYTE;
        piece_sz[2] = SZ_BYTE;
        if (op_size == SZ_WORD && lo_addr[0]) begin
            n_pieces    = 2'd2;
            piece_sz[0] = SZ_BYTE;
        end else if (op_size[1]) begin
            piece_sz[0] = SZ_LONG;
            if (lo_addr[0]) begin
                n_pieces    = 2'd3;
                piece_sz[0] = SZ_BYTE;
                piece_sz[1] = SZ_WORD;
            end else if (lo_addr[1]) begin
                n_pieces    = 2'd2;
                piece_sz[0] = SZ_WORD;
                piece_sz[1] = SZ_WORD;
            end
        end
    end

endmodule

// File: rtl/mis_split_steer.sv
module mis_split_steer
    import mis_split_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [2:0]        bytes_left,
    input  logic [1:0]        pc_size,
    input  logic              is_write,
    output logic [DATA_W-1:0] lane
);

    logic [2:0] lead;
    logic [5:0] shamt;

    always_comb begin
        lead  = bytes_left - size_bytes(pc_size);
        shamt = {lead, 3'b000};
        lane  = is_write ? ((operand >> shamt) & size_mask(pc_size)) : '0;
    end

endmodule

// File: rtl/mis_split_gather.sv
module mis_split_gather
    import mis_split_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] piece,
    input  logic [1:0]        pc_size,
    output logic [DATA_W-1:0] merged
);

    logic [5:0] shamt;

    always_comb begin
        shamt  = {size_bytes(pc_size), 3'b000};
        merged = (acc << shamt) | (piece & size_mask(pc_size));
    end

endmodule

// File: rtl/mis_split.sv
module mis_split
    import mis_split_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic [31:0]       rdata
);

    localparam int unsigned PAD_W = ADDR_W - 3;

    typedef enum logic {ST_IDLE, ST_XFER} state_e;

    state_e                     st_q;
    logic [ADDR_W-1:0]          addr_q;
    logic [1:0]                 idx_q;
    logic [1:0]                 npc_q;
    logic [MAX_PCS-1:0][1:0]    plan_q;
    logic [2:0]                 rem_q;
    logic                       write_q;
    logic [DATA_W-1:0]          wdata_q;
    logic [DATA_W-1:0]          acc_q;

    logic [1:0]                 plan_n;
    logic [MAX_PCS-1:0][1:0]    plan_sz;
    logic [1:0]                 cur_sz;
    logic                       last_pc;
    logic                       accept;
    logic [DATA_W-1:0]          lane;
    logic [DATA_W-1:0]          merged;

    mis_split_plan u_plan (
        .lo_addr  (req_addr[1:0]),
        .op_size  (req_size),
        .n_pieces (plan_n),
        .piece_sz (plan_sz)
    );

    mis_split_steer u_steer (
        .operand    (wdata_q),
        .bytes_left (rem_q),
        .pc_size    (cur_sz),
        .is_write   (write_q),
        .lane       (lane)
    );

    mis_split_gather u_gather (
        .acc     (acc_q),
        .piece   (bus_rdata),
        .pc_size (cur_sz),
        .merged  (merged)
    );

    always_comb begin
        unique case (idx_q)
            2'd0:    cur_sz = plan_q[0];
            2'd1:    cur_sz = plan_q[1];
            default: cur_sz = plan_q[2];
        endcase
        last_pc = (idx_q == npc_q - 2'd1);
        accept  = (st_q == ST_IDLE) && req_valid;
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            npc_q   <= 2'd1;
            plan_q  <= '0;
            rem_q   <= 3'd1;
            write_q <= 1'b0;
            wdata_q <= '0;
            acc_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin          // ACCEPT
                        st_q    <= ST_XFER;
                        addr_q  <= req_addr;
                        idx_q   <= '0;
                        npc_q   <= plan_n;
                        plan_q  <= plan_sz;
                        rem_q   <= size_bytes(req_size);
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        acc_q   <= '0;
                    end
                end
                ST_XFER: begin
                    if (last_pc) begin         // FINISH
                        st_q <= ST_IDLE;
                    end else begin             // STEP
                        addr_q <= addr_q + {{PAD_W{1'b0}}, size_bytes(cur_sz)};
                        idx_q  <= idx_q + 2'd1;
                        rem_q  <= rem_q - size_bytes(cur_sz);
                        acc_q  <= merged;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bus_valid = (st_q == ST_XFER);
        bus_addr  = addr_q;
        bus_size  = cur_sz;
        bus_write = write_q;
        bus_wdata = bus_valid ? lane : '0;
        done      = bus_valid && last_pc;
        rdata     = (done && !write_q) ? merged : '0;
    end

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R1

    AST_FIRST_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_valid && bus_addr == $past(req_addr))); // R1

    AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ((bus_size == SZ_BYTE) ||
                       (bus_size == SZ_WORD && !bus_addr[0]) ||
                       (bus_addr[1:0] == 2'b00))); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !done) |=> (bus_valid &&
            bus_addr == $past(bus_addr) + {{PAD_W{1'b0}}, size_bytes($past(bus_size))})); // R6

    AST_ODD_LONG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == SZ_LONG && req_addr[0])
        |=> (bus_size == SZ_BYTE && !done) ##1 (bus_size == SZ_WORD && !done)
            ##1 (bus_size == SZ_BYTE && done)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !done)); // R9

endmodule

// File: tb/mis_split_test.sv
module mis_split_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        done;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mis_split #(.ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .rdata(rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] * 8'd7 + 8'h3C;
    endfunction

    // Zero-wait memory with junk in unused upper lanes
    always_comb begin
        case (bus_size)
            2'd0:    bus_rdata = {24'hA5C3E1, mem_byte(bus_addr)};
            2'd1:    bus_rdata = {16'hF00D, mem_byte(bus_addr), mem_byte(bus_addr + 1)};
            default: bus_rdata = {mem_byte(bus_addr), mem_byte(bus_addr + 1),
                                  mem_byte(bus_addr + 2), mem_byte(bus_addr + 3)};
        endcase
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, input string tag);
        int unsigned paddr[$];
        int unsigned psz[$];
        logic [31:0] pw[$];
        int unsigned rem;
        int unsigned cur;
        int unsigned s;
        logic [31:0] exp_rd;
        logic [31:0] msk;
        rem = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp_rd = '0;
        for (int i = 0; i < rem; i++) exp_rd = (exp_rd << 8) | {24'h0, mem_byte(a + i)};
        cur = a;
        while (rem > 0) begin
            if (rem >= 4 && cur % 4 == 0) s = 4;
            else if (rem >= 2 && cur % 2 == 0) s = 2;
            else s = 1;
            msk = (s == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * s)) - 1);
            paddr.push_back(cur);
            psz.push_back(s);
            pw.push_back(wr ? ((wd >> (8 * (rem - s))) & msk) : 32'h0);
            cur += s;
            rem -= s;
        end
        @(negedge clk);
        chk("R1 ready before request", {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        // R1: request inputs wiggle while busy and must be ignored
        req_addr = a ^ 32'h0000_0013; req_size = 2'd2; req_write = ~wr; req_wdata = ~wd;
        for (int k = 0; k < paddr.size(); k++) begin
            chk("R1 ready low while busy", {31'h0, req_ready}, 32'h0);
            chk({tag, " transfer valid"}, {31'h0, bus_valid}, 32'h1);
            chk({tag, " piece size"}, {30'h0, bus_size},
                (psz[k] == 1) ? 32'd0 : (psz[k] == 2) ? 32'd1 : 32'd2);
            chk("R6 piece address", bus_addr, paddr[k]);
            chk("R7 direction", {31'h0, bus_write}, {31'h0, wr});
            chk("R7 store lanes", bus_wdata, pw[k]);
            chk("R9 done only on last", {31'h0, done}, (k == paddr.size() - 1) ? 32'h1 : 32'h0);
            if (k == paddr.size() - 1) chk("R8 load result", rdata, wr ? 32'h0 : exp_rd);
            else chk("R8 result zero before done", rdata, 32'h0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R1 ready after done", {31'h0, req_ready}, 32'h1);
        chk("R9 bus idle", {31'h0, bus_valid}, 32'h0);
        chk("R9 done low when idle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", {31'h0, req_ready}, 32'h1);
        chk("R10 bus idle in reset", {31'h0, bus_valid}, 32'h0);
        chk("R10 done low in reset", {31'h0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", {31'h0, req_ready}, 32'h1);
        run_req(32'h0000_0103, 2'd0, 1'b0, 32'h0, "R2");
        run_req(32'h0000_0047, 2'd0, 1'b1, 32'hFFFF_FF9A, "R2");
        run_req(32'h0000_0010, 2'd1, 1'b1, 32'hDEAD_1234, "R2");
        run_req(32'h0000_0208, 2'd2, 1'b0, 32'h0, "R2");
        run_req(32'h0000_0021, 2'd1, 1'b0, 32'h0, "R3");
        run_req(32'h0000_0033, 2'd1, 1'b1, 32'h7777_ABCD, "R3");
        run_req(32'h0000_0041, 2'd2, 1'b0, 32'h0, "R4");
        run_req(32'h0000_0053, 2'd2, 1'b0, 32'h0, "R4");
        run_req(32'h0000_00F5, 2'd2, 1'b1, 32'h1122_3344, "R4");
        run_req(32'h0000_0067, 2'd2, 1'b1, 32'hCAFE_F00D, "R4");
        run_req(32'h0000_0072, 2'd2, 1'b0, 32'h0, "R5");
        run_req(32'h0000_008A, 2'd2, 1'b1, 32'h5566_7788, "R5");
        run_req(32'hFFFF_FFFD, 2'd2, 1'b0, 32'h0, "R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule